// File: doc/BRIEF.md
# Coherence Response Classifier with Signed Ack Balance

This block sits beside the miss-handling state machine of a private cache controller. For the single outstanding miss it watches, it turns each arriving coherence response into exactly one controller event, and it keeps a signed running balance of invalidation acknowledgements still owed. Classification is combinational, so the event is visible in the same cycle as the response. The balance register changes on the next clock edge, and only when the controller reports that it has consumed the response.

The balance is signed because acknowledgements from other caches can arrive before the data reply. Data and acks both adjust the same counter. A response counts as "last" when the count it carries equals the balance still outstanding. Shared data supplied by a peer first-level cache is recognised from two inputs: the class of the sender and the line's current read-wait state.

The block has two parts. The decoder (`rsp_decode`) has no registers and picks one event per response, in a fixed priority order. The balance register (`ack_balance`) has three update paths: clear, subtract and hold. Clear is driven by reset or by allocation of a new transaction entry. Subtract happens when a consumed data or ack event arrives. Hold covers every other cycle.

Top module: `rsp_classifier`

## Requirements
- R1: While `rsp_valid_i` is 0 the event output is NONE (code 0) and `err_o` is 0.
- R2: A response of kind DATA_EXCL (kind code 1) gives event DATA_EXCL (code 4), whatever the balance and the ack field hold.
- R3: A DATA response (kind code 0) with `rsp_from_l1_i`=1 gives event DATA_PEER (code 3) while the line state is RD_WAIT (1), RD_WAIT_INV (2), PF_RD_WAIT (3) or PF_RD_WAIT_INV (4).
- R4: Any other DATA response gives DATA_ALL (code 2) when the current balance equals its ack field, and DATA (code 1) otherwise.
- R5: An ACK response (kind code 2) gives ACK_LAST (code 6) when the balance equals its ack field, and ACK (code 5) otherwise.
- R6: A WB_ACK response (kind code 3) gives event WB_ACK (code 7).
- R7: Kind codes 4 to 7 give event ERROR (code 8) with `err_o`=1.
- R8: When `consume_i`=1 and the event is DATA, DATA_ALL, ACK or ACK_LAST, the balance becomes balance minus the ack field on the next edge. The arithmetic is two's-complement signed, and negative results are kept.
- R9: When a consumed response gives DATA_PEER, DATA_EXCL, WB_ACK or ERROR, the balance is left unchanged. An unconsumed response also leaves it unchanged.
- R10: `alloc_i`=1 clears the balance to 0 on the next edge, and takes priority over a consume in the same cycle.
- R11: After reset the balance is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rsp_valid_i | input | 1 | A response is present this cycle |
| rsp_kind_i | input | 3 | Response kind: 0 DATA, 1 DATA_EXCL, 2 ACK, 3 WB_ACK, 4-7 illegal |
| rsp_from_l1_i | input | 1 | Sender is a peer first-level cache |
| rsp_acks_i | input | CNT_W | Signed ack-count field of the response |
| line_st_i | input | 3 | Transient state of the line (0 STABLE, 1-4 read waits, 5 WR_WAIT, 6 UPG_WAIT, 7 EVICT_WAIT) |
| consume_i | input | 1 | Controller consumes the present response |
| alloc_i | input | 1 | A transaction entry is allocated; clear the balance |
| evt_o | output | 4 | Classified event code |
| err_o | output | 1 | Illegal response kind |
| pending_o | output | CNT_W | Signed ack balance |

## Verification
The hardest situation to reach is acks overtaking the data: the balance goes negative, and the late data must then be recognised as final. The stimulus gets there by consuming two single-count acks right after allocation, before any data arrives. The balance falls to -2. A DATA reply carrying -2 must then classify as DATA_ALL and bring the balance back to zero. The opposite ordering, data first, is driven as well. Peer-shared data is driven in each of the four read-wait states and also in a write-wait state, so that the state condition that tells the two cases apart is exercised on both sides.

// File: rtl/rsp_classifier_pkg.sv
package rsp_classifier_pkg;

    localparam logic [2:0] KIND_DATA      = 3'd0;
    localparam logic [2:0] KIND_DATA_EXCL = 3'd1;
    localparam logic [2:0] KIND_ACK       = 3'd2;
    localparam logic [2:0] KIND_WB_ACK    = 3'd3;

    typedef enum logic [2:0] {
        ST_STABLE         = 3'd0,
        ST_RD_WAIT        = 3'd1,
        ST_RD_WAIT_INV    = 3'd2,
        ST_PF_RD_WAIT     = 3'd3,
        ST_PF_RD_WAIT_INV = 3'd4,
        ST_WR_WAIT        = 3'd5,
        ST_UPG_WAIT       = 3'd6,
        ST_EVICT_WAIT     = 3'd7
    } line_st_e;

    typedef enum logic [3:0] {
        EV_NONE      = 4'd0,
        EV_DATA      = 4'd1,
        EV_DATA_ALL  = 4'd2,
        EV_DATA_PEER = 4'd3,
        EV_DATA_EXCL = 4'd4,
        EV_ACK       = 4'd5,
        EV_ACK_LAST  = 4'd6,
        EV_WB_ACK    = 4'd7,
        EV_ERROR     = 4'd8
    } rsp_evt_e;

endpackage

// File: rtl/rsp_decode.sv
module rsp_decode
    import rsp_classifier_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic                    valid_i,
    input  logic [2:0]              kind_i,
    input  logic                    from_l1_i,
    input  logic signed [CNT_W-1:0] acks_i,
    input  logic [2:0]              line_st_i,
    input  logic signed [CNT_W-1:0] balance_i,
    output rsp_evt_e                evt_o,
    output logic                    err_o,
    output logic                    adjust_o
);

    logic in_read_wait;
    logic is_last;

    always_comb begin
        in_read_wait = (line_st_i == ST_RD_WAIT)    || (line_st_i == ST_RD_WAIT_INV) ||
                       (line_st_i == ST_PF_RD_WAIT) || (line_st_i == ST_PF_RD_WAIT_INV);
        is_last      = (balance_i == acks_i);
    end

    always_comb begin
        evt_o = EV_NONE;
        err_o = 1'b0;
        if (valid_i) begin
            unique case (kind_i)
                KIND_DATA: begin
                    if (from_l1_i && in_read_wait) evt_o = EV_DATA_PEER;
                    else if (is_last)              evt_o = EV_DATA_ALL;
                    else                           evt_o = EV_DATA;
                end
                KIND_DATA_EXCL: evt_o = EV_DATA_EXCL;
                KIND_ACK:       evt_o = is_last ? EV_ACK_LAST : EV_ACK;
                KIND_WB_ACK:    evt_o = EV_WB_ACK;
                default: begin
                    evt_o = EV_ERROR;
                    err_o = 1'b1;
                end
            endcase
        end
    end

    always_comb begin
        unique case (evt_o)
            EV_DATA, EV_DATA_ALL, EV_ACK, EV_ACK_LAST: adjust_o = 1'b1;
            default:                                  adjust_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/ack_balance.sv
module ack_balance #(
    parameter int CNT_W = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    alloc_i,
    input  logic                    take_i,
    input  logic signed [CNT_W-1:0] acks_i,
    output logic signed [CNT_W-1:0] balance_o
);

    logic signed [CNT_W-1:0] bal_q;
    logic signed [CNT_W-1:0] bal_d;

    always_comb begin
        if (alloc_i)     bal_d = '0;
        else if (take_i) bal_d = bal_q - acks_i;
        else             bal_d = bal_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bal_q <= '0;
        else        bal_q <= bal_d;
    end

    assign balance_o = bal_q;

endmodule

// File: rtl/rsp_classifier.sv
module rsp_classifier
    import rsp_classifier_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rsp_valid_i,
    input  logic [2:0]              rsp_kind_i,
    input  logic                    rsp_from_l1_i,
    input  logic signed [CNT_W-1:0] rsp_acks_i,
    input  logic [2:0]              line_st_i,
    input  logic                    consume_i,
    input  logic                    alloc_i,
    output logic [3:0]              evt_o,
    output logic                    err_o,
    output logic signed [CNT_W-1:0] pending_o
);

    rsp_evt_e                evt;
    logic                    adjust;
    logic signed [CNT_W-1:0] balance;

    rsp_decode #(.CNT_W(CNT_W)) dec_i (
        .valid_i   (rsp_valid_i),
        .kind_i    (rsp_kind_i),
        .from_l1_i (rsp_from_l1_i),
        .acks_i    (rsp_acks_i),
        .line_st_i (line_st_i),
        .balance_i (balance),
        .evt_o     (evt),
        .err_o     (err_o),
        .adjust_o  (adjust)
    );

    ack_balance #(.CNT_W(CNT_W)) bal_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_i   (alloc_i),
        .take_i    (consume_i && adjust),
        .acks_i    (rsp_acks_i),
        .balance_o (balance)
    );

    assign evt_o     = evt;
    assign pending_o = balance;

endmodule

// File: rtl/rsp_classifier_chk.sv
module rsp_classifier_chk #(
    parameter int CNT_W = 6
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    rsp_valid_i,
    input logic [2:0]              rsp_kind_i,
    input logic                    consume_i,
    input logic                    alloc_i,
    input logic signed [CNT_W-1:0] rsp_acks_i,
    input logic [3:0]              evt_o,
    input logic                    err_o,
    input logic signed [CNT_W-1:0] pending_o
);

    logic takes;
    logic holds;
    assign takes = rsp_valid_i && consume_i && !alloc_i &&
                   (evt_o == 4'd1 || evt_o == 4'd2 || evt_o == 4'd5 || evt_o == 4'd6);
    assign holds = !alloc_i && !takes;

    a_r1_idle_none: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid_i |-> (evt_o == 4'd0 && !err_o));

    a_r2_excl_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_i && rsp_kind_i == 3'd1) |-> evt_o == 4'd4);

    a_r7_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (evt_o == 4'd8 && rsp_kind_i[2]));

    a_r8_subtract: assert property (@(posedge clk) disable iff (!rst_n)
        takes |=> pending_o == CNT_W'($past(pending_o) - $past(rsp_acks_i)));

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        holds |=> $stable(pending_o));

    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |=> pending_o == '0);

endmodule

bind rsp_classifier rsp_classifier_chk #(.CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rsp_valid_i (rsp_valid_i),
    .rsp_kind_i  (rsp_kind_i),
    .consume_i   (consume_i),
    .alloc_i     (alloc_i),
    .rsp_acks_i  (rsp_acks_i),
    .evt_o       (evt_o),
    .err_o       (err_o),
    .pending_o   (pending_o)
);

// File: tb/rsp_classifier_tb_top.sv
`timescale 1ns/1ps
module rsp_classifier_tb_top;

    localparam int CNT_W = 6;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    rsp_valid_i = 1'b0;
    logic [2:0]              rsp_kind_i = 3'd0;
    logic                    rsp_from_l1_i = 1'b0;
    logic signed [CNT_W-1:0] rsp_acks_i = '0;
    logic [2:0]              line_st_i = 3'd0;
    logic                    consume_i = 1'b0;
    logic                    alloc_i = 1'b0;
    logic [3:0]              evt_o;
    logic                    err_o;
    logic signed [CNT_W-1:0] pending_o;

    int checks = 0;
    int errors = 0;
    int exp_bal = 0;

    always #5 clk = ~clk;

    rsp_classifier #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .rsp_valid_i(rsp_valid_i), .rsp_kind_i(rsp_kind_i),
        .rsp_from_l1_i(rsp_from_l1_i), .rsp_acks_i(rsp_acks_i), .line_st_i(line_st_i),
        .consume_i(consume_i), .alloc_i(alloc_i), .evt_o(evt_o), .err_o(err_o),
        .pending_o(pending_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Present one response, check its event, clock it, check the balance.
    task automatic send(input string req, input logic [2:0] kind, input logic l1,
                        input int acks, input logic [2:0] st, input logic cons,
                        input logic alc, input int exp_evt);
        @(negedge clk);
        rsp_valid_i = 1'b1; rsp_kind_i = kind; rsp_from_l1_i = l1;
        rsp_acks_i = CNT_W'(acks); line_st_i = st; consume_i = cons; alloc_i = alc;
        #1;
        chk({req, " event"}, int'(evt_o), exp_evt);
        chk({req, " err"}, int'(err_o), (exp_evt == 8) ? 1 : 0);
        if (alc) exp_bal = 0;
        else if (cons && (exp_evt == 1 || exp_evt == 2 || exp_evt == 5 || exp_evt == 6))
            exp_bal = exp_bal - acks;
        @(posedge clk); #1;
        rsp_valid_i = 1'b0; consume_i = 1'b0; alloc_i = 1'b0;
        chk({req, " balance"}, int'(pending_o), exp_bal);
    endtask

    task automatic do_alloc();
        @(negedge clk); alloc_i = 1'b1;
        @(posedge clk); #1; alloc_i = 1'b0; exp_bal = 0;
        chk("R10 alloc clear", int'(pending_o), 0);
    endtask

    task automatic t_reset();
        #1;
        chk("R11 reset balance", int'(pending_o), 0);
        chk("R1 idle event", int'(evt_o), 0);
        chk("R1 idle err", int'(err_o), 0);
    endtask

    task automatic t_data_first();
        do_alloc();
        send("R4 data first", 3'd0, 1'b0, -2, 3'd5, 1'b1, 1'b0, 1);
        send("R5 ack mid",    3'd2, 1'b1,  1, 3'd5, 1'b1, 1'b0, 5);
        send("R5 ack last",   3'd2, 1'b1,  1, 3'd5, 1'b1, 1'b0, 6);
    endtask

    task automatic t_acks_first();
        do_alloc();
        send("R8 early ack 1", 3'd2, 1'b1, 1, 3'd5, 1'b1, 1'b0, 5);
        send("R8 early ack 2", 3'd2, 1'b1, 1, 3'd5, 1'b1, 1'b0, 5);
        chk("R8 negative balance", int'(pending_o), -2);
        send("R4 late data all", 3'd0, 1'b0, -2, 3'd5, 1'b1, 1'b0, 2);
    endtask

    task automatic t_peer();
        do_alloc();
        for (int s = 1; s <= 4; s++)
            send("R3 peer data", 3'd0, 1'b1, 0, 3'(s), 1'b1, 1'b0, 3);
        send("R9 peer keeps balance", 3'd0, 1'b1, 5, 3'd1, 1'b1, 1'b0, 3);
        send("R4 l1 data in write wait", 3'd0, 1'b1, 0, 3'd5, 1'b1, 1'b0, 2);
        send("R4 l2 data in read wait",  3'd0, 1'b0, 3, 3'd1, 1'b1, 1'b0, 1);
    endtask

    task automatic t_others();
        send("R2 excl equal", 3'd1, 1'b0, exp_bal, 3'd5, 1'b1, 1'b0, 4);
        send("R2 excl unequal", 3'd1, 1'b1, 7, 3'd1, 1'b1, 1'b0, 4);
        send("R6 wb ack", 3'd3, 1'b0, 2, 3'd7, 1'b1, 1'b0, 7);
        for (int k = 4; k <= 7; k++)
            send("R7 illegal kind", 3'(k), 1'b0, 1, 3'd0, 1'b1, 1'b0, 8);
        send("R9 unconsumed ack", 3'd2, 1'b0, 1, 3'd5, 1'b0, 1'b0, 5);
        send("R10 alloc beats consume", 3'd2, 1'b0, 1, 3'd5, 1'b1, 1'b1, 5);
        @(negedge clk); #1;
        chk("R1 idle after", int'(evt_o), 0);
    endtask

    initial begin
        #1000000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        #20; rst_n = 1'b1;
        t_data_first();
        t_acks_first();
        t_peer();
        t_others();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule